// File: doc/BRIEF.md
# Nonvolatile Memory Timing Clock Divider

This block turns the fast bus clock into the slow timing base used by the program and erase sequencer of an on-chip nonvolatile array. It does not make a new clock. It sends out a one-cycle enable strobe in the bus clock domain at the divided rate. The divide ratio comes from an 8-bit control register that the register bus writes once after reset. The register has three parts: a 6-bit divide field, a prescaler enable that adds a divide-by-8 stage ahead of the programmable divider, and a read-only flag that shows the register has been loaded.

The strobe rate is the prescaled clock divided by one plus the divide field. Set the prescaler when the bus clock is above 12.8 MHz, so that the result falls near the 150–200 kHz band the algorithms expect. A slower timing base makes program and erase times longer in proportion to its period. The command controller reads the loaded status and blocks every command until the divider is set. While the flag is clear, the divider stays in reset and sends out no strobes.

Top module: `nvm_tclk_div`

## Requirements
- R1: After reset, the read data is 0x00, `loaded_o` is 0 and `tick_o` is 0.
- R2: Register layout: bits 5:0 hold the divide field, bit 6 is the prescaler enable and bit 7 is the loaded flag. The first write after reset stores bits 6:0 and sets bit 7. The read data and `loaded_o` show this in the cycle after the write edge.
- R3: Once the loaded flag is set, any further write has no effect. Bits 6:0 and the strobe rate stay the same until the next reset.
- R4: Bit 7 of the write data is ignored. A first write of 0x00 still sets the flag, and a first write of 0x80 reads back as 0x80.
- R5: While the loaded flag is clear, `tick_o` stays low, however long that lasts.
- R6: With the prescaler off, `tick_o` pulses every 1+D bus cycles, where D is the divide field. Count the cycle right after the loading edge as cycle 0. The first pulse comes in cycle D.
- R7: With the prescaler on, `tick_o` pulses every 8*(1+D) bus cycles. The first pulse comes in cycle 8*(1+D)-1.
- R8: `tick_o` is high for one cycle only, except when D=0 with the prescaler off. In that case it is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Control register read data: loaded flag, prescaler enable, divide field |
| tick_o | output | 1 | One-cycle timing enable at the divided rate |
| loaded_o | output | 1 | Divider loaded status for the command controller |

## Verification
The hardest case to reach from the ports is a second write that lands after the register is already loaded. Its effect shows only over whole strobe periods. The bench first loads a small divide value and then writes a different value, with the prescaler bit set. It then measures the next pulse phase and period and checks they still match the first value. It also checks that the read data did not change. The largest divide value with the prescaler on gives a 512-cycle period, and measuring it makes sure the counter wraps at the full field width.

// File: rtl/nvm_tclk_pkg.sv
package nvm_tclk_pkg;
  localparam int unsigned TCLK_DIV_W = 6;
  localparam int unsigned TCLK_REG_W = TCLK_DIV_W + 2;

  typedef struct packed {
    logic                  pre_en;
    logic [TCLK_DIV_W-1:0] div;
  } tclk_cfg_t;
endpackage

// File: rtl/nvm_tclk_cfg_reg.sv
module nvm_tclk_cfg_reg
  import nvm_tclk_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [TCLK_REG_W-1:0] wdata_i,
  output tclk_cfg_t             cfg_o,
  output logic                  loaded_o
);
  tclk_cfg_t cfg_q;
  logic      loaded_q;

  // write-once: only the first write after reset lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else if (we_i && !loaded_q) begin
      cfg_q    <= tclk_cfg_t'(wdata_i[TCLK_REG_W-2:0]);
      loaded_q <= 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/nvm_tclk_prescale.sv
module nvm_tclk_prescale #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bypass_i,
  output logic stb_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = en_i && (bypass_i || (cnt_q == LAST));
endmodule

// File: rtl/nvm_tclk_divider.sv
module nvm_tclk_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         stb_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (stb_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && stb_i && wrap;
endmodule

// File: rtl/nvm_tclk_div.sv
module nvm_tclk_div
  import nvm_tclk_pkg::*;
#(
  parameter int unsigned PRE_RATIO = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [TCLK_REG_W-1:0] reg_wdata_i,
  output logic [TCLK_REG_W-1:0] reg_rdata_o,
  output logic                  tick_o,
  output logic                  loaded_o
);
  tclk_cfg_t cfg;
  logic      loaded;
  logic      pre_stb;

  nvm_tclk_cfg_reg i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .cfg_o    (cfg),
    .loaded_o (loaded)
  );

  nvm_tclk_prescale #(.RATIO(PRE_RATIO)) i_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (loaded),
    .bypass_i (!cfg.pre_en),
    .stb_o    (pre_stb)
  );

  nvm_tclk_divider #(.W(TCLK_DIV_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (loaded),
    .stb_i   (pre_stb),
    .limit_i (cfg.div),
    .tick_o  (tick_o)
  );

  assign reg_rdata_o = {loaded, cfg};
  assign loaded_o    = loaded;
endmodule

// File: rtl/nvm_tclk_div_chk.sv
module nvm_tclk_div_chk
  import nvm_tclk_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [TCLK_REG_W-1:0] reg_wdata_i,
  input logic [TCLK_REG_W-1:0] reg_rdata_o,
  input logic                  tick_o,
  input logic                  loaded_o
);
  localparam int unsigned FLAG = TCLK_REG_W - 1;
  localparam int unsigned PRE  = TCLK_REG_W - 2;

  p_no_tick_unloaded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_o |-> !tick_o);

  p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |=> loaded_o);

  p_first_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !loaded_o) |=>
      (reg_rdata_o[FLAG] && reg_rdata_o[PRE:0] == $past(reg_wdata_i[PRE:0])));

  p_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |=> $stable(reg_rdata_o));

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (reg_rdata_o[PRE] || reg_rdata_o[PRE-1:0] != '0)) |=> !tick_o);

  p_flag_matches_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o == reg_rdata_o[FLAG]);
endmodule

bind nvm_tclk_div nvm_tclk_div_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .tick_o      (tick_o),
  .loaded_o    (loaded_o)
);

// File: tb/test_nvm_tclk_div.sv
`timescale 1ns/1ps
module test_nvm_tclk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       tick_o;
  logic       loaded_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  nvm_tclk_div i_nvm_tclk_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .tick_o      (tick_o),
    .loaded_o    (loaded_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    reg_we_i = 1'b0;
    rst_ni   = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // write lands at next posedge; returns at the negedge after it (cycle 0)
  task automatic write_reg(logic [7:0] v);
    @(negedge clk_i);
    reg_we_i    = 1'b1;
    reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // from the current cycle, index of first tick and gap to the next
  task automatic measure(int limit, output int first, output int period);
    int second = -1;
    first = -1;
    for (int i = 0; i < limit && second < 0; i++) begin
      if (tick_o) begin
        if (first < 0) first = i;
        else second = i;
      end
      @(negedge clk_i);
    end
    period = (first >= 0 && second >= 0) ? second - first : -1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 rdata", reg_rdata_o, 8'h00);
    check("R1 loaded", loaded_o, 0);
    check("R1 tick", tick_o, 0);
  endtask

  task automatic t_idle_no_tick();
    int seen = 0;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      if (tick_o) seen++;
      @(negedge clk_i);
    end
    check("R5 ticks while unloaded", seen, 0);
    check("R5 loaded", loaded_o, 0);
  endtask

  task automatic t_plain(int d);
    int f, p;
    do_reset();
    write_reg(8'(d));
    check("R2 rdata", reg_rdata_o, 8'h80 | d);
    check("R2 loaded", loaded_o, 1);
    measure(400, f, p);
    check("R6 first tick", f, d);
    check("R6 period", p, d + 1);
  endtask

  task automatic t_continuous();
    int seen = 0;
    do_reset();
    write_reg(8'h00);
    for (int i = 0; i < 10; i++) begin
      if (tick_o) seen++;
      @(negedge clk_i);
    end
    check("R8 d0 continuous", seen, 10);
  endtask

  task automatic t_pulse_width();
    int hi = 0, run = 0;
    do_reset();
    write_reg(8'h41);
    for (int i = 0; i < 100; i++) begin
      if (tick_o) run++; else run = 0;
      if (run > hi) hi = run;
      @(negedge clk_i);
    end
    check("R8 max pulse run", hi, 1);
  endtask

  task automatic t_prescaled(int d);
    int f, p;
    do_reset();
    write_reg(8'h40 | 8'(d));
    check("R2 rdata pre", reg_rdata_o, 8'hC0 | d);
    measure(2000, f, p);
    check("R7 first tick", f, 8 * (d + 1) - 1);
    check("R7 period", p, 8 * (d + 1));
  endtask

  task automatic t_rewrite();
    int f, p;
    do_reset();
    write_reg(8'h02);
    @(negedge clk_i);
    write_reg(8'h45);
    check("R3 rdata after rewrite", reg_rdata_o, 8'h82);
    measure(200, f, p);
    check("R3 period after rewrite", p, 3);
    check("R3 first tick phase", (f >= 0 && f < 3) ? 1 : 0, 1);
    write_reg(8'h00);
    check("R3 rdata after second rewrite", reg_rdata_o, 8'h82);
  endtask

  task automatic t_bit7_ignored();
    do_reset();
    write_reg(8'h80);
    check("R4 rdata 0x80", reg_rdata_o, 8'h80);
    check("R4 loaded", loaded_o, 1);
    do_reset();
    write_reg(8'h00);
    check("R4 flag on 0x00", reg_rdata_o, 8'h80);
  endtask

  initial begin
    t_reset_state();
    t_idle_no_tick();
    t_plain(3);
    t_plain(17);
    t_continuous();
    t_pulse_width();
    t_prescaled(1);
    t_prescaled(63);
    t_rewrite();
    t_bit7_ignored();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule